// File: doc/BRIEF.md
# Floppy Spindle Motor Timer

This block sits on the drive side of a floppy interface and decides when the spindle motor driver is powered. The host asks for spin through an active-low motor request line. That line is honoured whether or not the drive is currently selected. A rising edge on the door-closed input also spins the disk for a fixed self-timed window, so the media can seat even when no host request is present. A host request that arrives during that window takes over: the timed shutoff is cancelled, and the motor then follows the host line alone.

A second timer watches the motor output. It raises a speed-stable flag once the spindle has had the full settle interval to reach speed. Both windows are given in milliseconds and converted to clock cycles from a clock-frequency parameter. A simulation can therefore run with a small clock frequency and keep the same millisecond settings.

Top module: `spindle_motor_timer`

## Requirements
- R1: `motor_on_n_i` low turns `motor_en_o` on after exactly two clock edges (two-stage synchroniser). There is no select input; the request acts unconditionally.
- R2: With no door window running, `motor_on_n_i` going high turns `motor_en_o` off after exactly two clock edges.
- R3: `spin_ready_o` rises exactly `SETTLE_MS*CLK_HZ/1000` clock edges after `motor_en_o` rises, and stays high while the motor stays on.
- R4: `spin_ready_o` falls in the same cycle that `motor_en_o` falls. The next turn-on waits the whole settle interval again.
- R5: A rising edge on `door_closed_i` (high means closed) turns the motor on three clock edges later. The motor then stays on for exactly `RUN_MS*CLK_HZ/1000` cycles and turns off, with the host request inactive.
- R6: A door input held high starts only one window. A new window needs the input to go low and then high again.
- R7: A door edge during a running window restarts the full window from that edge.
- R8: A host request during a door window cancels the window. The motor stays on without a gap and `spin_ready_o` is not restarted. When the request is released, the motor stops two edges later.
- R9: A door edge while the host request is active starts no window. Releasing the request stops the motor two edges later.
- R10: While `rst_n_i` is low, `motor_en_o` and `spin_ready_o` are 0 at once (asynchronous reset), and no window survives the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock at `CLK_HZ` |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| motor_on_n_i | input | 1 | Host spin request, active low, asynchronous |
| door_closed_i | input | 1 | Door latch state, high when closed, asynchronous |
| motor_en_o | output | 1 | Enable to the spindle motor driver |
| spin_ready_o | output | 1 | Spindle speed settled |

## Verification
The assertions assume that both asynchronous inputs hold each level for at least one full clock period, so that the synchroniser sees every door pulse. They also assume `CLK_HZ` is a whole number of kilohertz, which gives settle and run windows of at least one cycle. The stimulus changes inputs only on the falling clock edge, keeps every door pulse at least one cycle wide, and scales `CLK_HZ` down to 2 kHz. With that value the run window lasts ten thousand cycles and the settle window five hundred, and the bench counts each of them to the exact edge.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

   // Who is keeping the spindle turning
   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_HOST = 2'd1,
      SRC_DOOR = 2'd2
   } motor_src_e;

   // Milliseconds to clock cycles for a clock given in Hz
   function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                input int unsigned ms);
      return (clk_hz / 1000) * ms;
   endfunction

   // Counter width able to hold the value n
   function automatic int unsigned width_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/mctl_sync.sv
module mctl_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          EDGE_OUT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   if (EDGE_OUT) begin : g_edge
      logic prev_q;

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            prev_q <= 1'b0;
         end else begin
            prev_q <= chain_q[STAGES-1];
         end
      end

      assign q_o = chain_q[STAGES-1] & ~prev_q;

      // R6
      single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         q_o |=> !q_o);
   end else begin : g_level
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/mctl_run_timer.sv
module mctl_run_timer
   import mctl_pkg::*;
#(
   parameter int unsigned RUN_CYC = 40_000_000
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic trig_i,
   input  logic hold_i,
   output logic active_o
);

   localparam int unsigned CW = width_for(RUN_CYC);
   localparam logic [CW-1:0] LAST = CW'(RUN_CYC - 1);

   if (RUN_CYC < 1) begin : g_bad_run
      $error("mctl_run_timer: RUN_CYC must be at least 1");
   end

   logic          active_q;
   logic [CW-1:0] cnt_q;

   // The host request wins over the door event, and a new door event reloads
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (hold_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (trig_i) begin
         active_q <= 1'b1;
         cnt_q    <= LAST;
      end else if (active_q) begin
         if (cnt_q == '0) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign active_o = active_q;

   // R8
   hold_cancels_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      hold_i |=> !active_q);

   // R7
   trig_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (trig_i && !hold_i) |=> (active_q && cnt_q == LAST));

   // R5
   expire_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(active_q) |-> ($past(hold_i) || $past(cnt_q) == '0));

   // R5
   countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (active_q && !hold_i && !trig_i && cnt_q != '0)
         |=> (active_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mctl_settle_timer.sv
module mctl_settle_timer
   import mctl_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 2_000_000
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic run_i,
   output logic ready_o
);

   localparam int unsigned CW = width_for(SETTLE_CYC);
   localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("mctl_settle_timer: SETTLE_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   // Counts cycles with the motor on, saturating at the limit
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready_o = run_i && (cnt_q == LIMIT);

   // R3
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_q <= LIMIT);

   // R4
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(run_i) |-> (cnt_q == '0));

   // R3
   ready_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ready_o |-> $past(run_i));

endmodule

// File: rtl/spindle_motor_timer.sv
module spindle_motor_timer
   import mctl_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 8_000_000,
   parameter int unsigned SETTLE_MS   = 250,
   parameter int unsigned RUN_MS      = 5000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic motor_on_n_i,
   input  logic door_closed_i,
   output logic motor_en_o,
   output logic spin_ready_o
);

   localparam int unsigned SETTLE_CYC = ms_to_cycles(CLK_HZ, SETTLE_MS);
   localparam int unsigned RUN_CYC    = ms_to_cycles(CLK_HZ, RUN_MS);

   if (CLK_HZ < 1000 || (CLK_HZ % 1000) != 0) begin : g_bad_clk
      $error("spindle_motor_timer: CLK_HZ must be a whole number of kHz");
   end
   if (SETTLE_MS < 1 || RUN_MS < 1) begin : g_bad_ms
      $error("spindle_motor_timer: windows must be at least 1 ms");
   end

   logic       host_on;
   logic       door_pulse;
   logic       run_active;
   motor_src_e src;

   mctl_sync #(
      .STAGES  (SYNC_STAGES),
      .EDGE_OUT(1'b0)
   ) host_sync_i (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .d_i    (~motor_on_n_i),
      .q_o    (host_on)
   );

   mctl_sync #(
      .STAGES  (SYNC_STAGES),
      .EDGE_OUT(1'b1)
   ) door_sync_i (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .d_i    (door_closed_i),
      .q_o    (door_pulse)
   );

   mctl_run_timer #(
      .RUN_CYC(RUN_CYC)
   ) run_tmr_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .trig_i  (door_pulse),
      .hold_i  (host_on),
      .active_o(run_active)
   );

   always_comb begin
      if (host_on) begin
         src = SRC_HOST;
      end else if (run_active) begin
         src = SRC_DOOR;
      end else begin
         src = SRC_OFF;
      end
   end

   assign motor_en_o = (src != SRC_OFF);

   mctl_settle_timer #(
      .SETTLE_CYC(SETTLE_CYC)
   ) settle_tmr_i (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .run_i  (motor_en_o),
      .ready_o(spin_ready_o)
   );

   // R4
   ready_needs_motor_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      spin_ready_o |-> motor_en_o);

   // R3
   not_ready_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(motor_en_o) |-> !spin_ready_o);

   // R9
   door_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (door_pulse && host_on) |=> !run_active);

endmodule

// File: tb/spindle_motor_timer_tb_top.sv
`timescale 1ns/1ps
module spindle_motor_timer_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic motor_on_n = 1'b1;
   logic door = 1'b0;
   logic motor_en;
   logic spin_ready;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // 2 kHz: settle 500 cycles, run window 10000 cycles
   spindle_motor_timer #(
      .CLK_HZ     (2000),
      .SETTLE_MS  (250),
      .RUN_MS     (5000),
      .SYNC_STAGES(2)
   ) dut_i (
      .clk_i        (clk),
      .rst_n_i      (rst_n),
      .motor_on_n_i (motor_on_n),
      .door_closed_i(door),
      .motor_en_o   (motor_en),
      .spin_ready_o (spin_ready)
   );

   typedef struct packed {
      logic        mon_n;
      logic        dr;
      logic [15:0] cyc;
      logic        en;
      logic        rdy;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 33;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 16'd1,     1'b0, 1'b0, 4'd1},  // R1 still in synchroniser
      '{1'b0, 1'b0, 16'd1,     1'b1, 1'b0, 4'd1},  // R1 on after two edges
      '{1'b0, 1'b0, 16'd499,   1'b1, 1'b0, 4'd3},  // R3 one short of settle
      '{1'b0, 1'b0, 16'd1,     1'b1, 1'b1, 4'd3},  // R3 settled
      '{1'b1, 1'b0, 16'd1,     1'b1, 1'b1, 4'd2},  // R2 release in flight
      '{1'b1, 1'b0, 16'd1,     1'b0, 1'b0, 4'd4},  // R4 ready drops with motor
      '{1'b1, 1'b0, 16'd10,    1'b0, 1'b0, 4'd2},  // R2 stays off
      '{1'b0, 1'b0, 16'd2,     1'b1, 1'b0, 4'd1},  // R1 second start
      '{1'b0, 1'b0, 16'd250,   1'b1, 1'b0, 4'd4},  // R4 settle restarted
      '{1'b0, 1'b0, 16'd250,   1'b1, 1'b1, 4'd4},  // R4 full settle again
      '{1'b1, 1'b0, 16'd2,     1'b0, 1'b0, 4'd2},  // R2 off
      '{1'b1, 1'b1, 16'd2,     1'b0, 1'b0, 4'd5},  // R5 door edge in flight
      '{1'b1, 1'b1, 16'd1,     1'b1, 1'b0, 4'd5},  // R5 on after three edges
      '{1'b1, 1'b1, 16'd500,   1'b1, 1'b1, 4'd3},  // R3 ready in door window
      '{1'b1, 1'b1, 16'd9499,  1'b1, 1'b1, 4'd5},  // R5 last window cycle
      '{1'b1, 1'b1, 16'd1,     1'b0, 1'b0, 4'd5},  // R5 window over
      '{1'b1, 1'b1, 16'd100,   1'b0, 1'b0, 4'd6},  // R6 held door no retrigger
      '{1'b1, 1'b0, 16'd10,    1'b0, 1'b0, 4'd6},  // R6 door opened
      '{1'b1, 1'b1, 16'd3,     1'b1, 1'b0, 4'd7},  // R7 first window
      '{1'b1, 1'b0, 16'd5000,  1'b1, 1'b1, 4'd7},  // R7 mid window
      '{1'b1, 1'b1, 16'd3,     1'b1, 1'b1, 4'd7},  // R7 retrigger
      '{1'b1, 1'b0, 16'd9000,  1'b1, 1'b1, 4'd7},  // R7 past first window end
      '{1'b1, 1'b0, 16'd999,   1'b1, 1'b1, 4'd7},  // R7 last cycle of reload
      '{1'b1, 1'b0, 16'd1,     1'b0, 1'b0, 4'd7},  // R7 reload expired
      '{1'b1, 1'b1, 16'd3,     1'b1, 1'b0, 4'd8},  // R8 door window starts
      '{1'b0, 1'b1, 16'd600,   1'b1, 1'b1, 4'd8},  // R8 host joins, no gap
      '{1'b0, 1'b0, 16'd10000, 1'b1, 1'b1, 4'd8},  // R8 past window, host keeps on
      '{1'b1, 1'b0, 16'd2,     1'b0, 1'b0, 4'd8},  // R8 release stops
      '{1'b0, 1'b0, 16'd5,     1'b1, 1'b0, 4'd9},  // R9 host on
      '{1'b0, 1'b1, 16'd10,    1'b1, 1'b0, 4'd9},  // R9 door edge under host
      '{1'b1, 1'b1, 16'd2,     1'b0, 1'b0, 4'd9},  // R9 no window started
      '{1'b1, 1'b1, 16'd100,   1'b0, 1'b0, 4'd9},  // R9 stays off
      '{1'b1, 1'b0, 16'd10,    1'b0, 1'b0, 4'd9}   // R9 idle
   };

   task automatic check(input int req, input logic e_en, input logic e_rdy);
      checks++;
      if (motor_en !== e_en || spin_ready !== e_rdy) begin
         failures++;
         $display("FAIL R%0d: motor_en=%b spin_ready=%b expected motor_en=%b spin_ready=%b at %0t",
                  req, motor_en, spin_ready, e_en, e_rdy, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      check(10, 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(10, 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         motor_on_n = VECS[i].mon_n;
         door       = VECS[i].dr;
         repeat (int'(VECS[i].cyc)) @(posedge clk);
         @(negedge clk);
         check(int'(VECS[i].req), VECS[i].en, VECS[i].rdy);
      end

      // R5 single-cycle door pulse is caught
      door = 1'b1;
      @(posedge clk);
      @(negedge clk);
      door = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(5, 1'b0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check(5, 1'b1, 1'b0);

      // R10 asynchronous reset mid window, window does not resume
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(10, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(10, 1'b0, 1'b0);

      // R1 host request held across reset release
      motor_on_n = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(1, 1'b0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check(1, 1'b1, 1'b0);
      motor_on_n = 1'b1;
      repeat (4) @(negedge clk);

      finish_run();
   end

endmodule